// File: doc/BRIEF.md
# Two-Frame Asynchronous Result Transmitter

This block sends a 16-bit measurement word to a host as two asynchronous serial frames. The host supplies the shift clock, so the host also sets the baud rate. Every frame holds 11 bits: a low start bit, eight data bits sent least significant bit first, and two high stop bits. The frame that carries the upper byte goes out first.

A free-running cycle of `PERIOD` master clocks decides when a new word is taken from the parallel input. The active-low ready line stays low for most of the cycle. It then goes high for `HIGH_CYC` clocks, and it falls again on the edge where the next word is loaded. The host opens frame one by holding chip-select low across a falling edge of the shift clock. Frame two needs only chip-select low, and it must begin before the ready line would next rise. If it does not, the unsent byte is dropped and the word is replaced.

While a frame is on the wire, the cycle counter waits just before the high window. This keeps the word steady. The serial line is modelled as a data bit plus a separate drive-enable output.

Top module: `dpkt_uart_tx`

## Requirements
- R1: While reset is held, `rdy_n` is 1, `sdo_en` is 0 and `sdo_o` is 1. After reset is released, `rdy_n` falls on the `HIGH_CYC`-th clock edge, and the word on `word_in` is loaded on that same edge.
- R2: When no transfer is active, `rdy_n` is low for `PERIOD-HIGH_CYC` clocks and then high for `HIGH_CYC` clocks. It falls again on the edge where `word_in` is loaded.
- R3: A frame is 11 bits, in this order: bit 0 is the start bit (0), bits 1 to 8 are the data byte with its bit 0 first, and bits 9 and 10 are stop bits (1). A frame bit changes only on a falling edge of `sclk_in`, after a two-stage synchroniser into the `clk` domain.
- R4: Frame one carries `word[15:8]`. Frame two carries `word[7:0]`.
- R5: Frame one starts only on a falling edge of `sclk_in` seen while `cs_n` is low and `rdy_n` is low. Holding `cs_n` low without shift edges does not start a frame, and neither do shift edges while `cs_n` is high.
- R6: If `cs_n` rises during frame one, the frame still runs through its second stop bit. On the next falling edge of `sclk_in`, `sdo_en` drops to 0.
- R7: After frame one, a short low level on `cs_n` starts frame two with no shift-clock edge. The start bit is driven at once, and the remaining bits advance on the following shift-clock falling edges.
- R8: If frame two has not started by the time `rdy_n` would rise, the low byte is dropped. `rdy_n` then rises, a later `cs_n` pulse does not start a frame, and the next transfer sends the new word.
- R9: With `cs_n` held low, the 22 bits go out back to back, and `rdy_n` stays low until the last stop bit has ended.
- R10: While a frame is being sent, `rdy_n` stays low and the stored word does not change. Once the transfer ends, `rdy_n` goes high for `HIGH_CYC` clocks and the next word is loaded.
- R11: `sdo_en` is 1 only while a frame is being sent. When it is 0, `sdo_o` is 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| sclk_in | input | 1 | Shift clock from the host; sets the baud rate |
| cs_n | input | 1 | Chip-select, active low |
| word_in | input | 16 | Parallel result word |
| rdy_n | output | 1 | Data-ready, active low |
| sdo_o | output | 1 | Serial data value |
| sdo_en | output | 1 | Drive enable for the serial line; 0 means high impedance |

## Verification
The bench builds the block with `PERIOD` = 256 and `HIGH_CYC` = 4, and keeps the default synchroniser depth. With this shorter cycle, a shift clock with 8 master clocks per bit fits both frames before the counter's gate point, so the short-pulse start of frame two can be exercised. A shift clock with 32 master clocks per bit overruns the gate, which forces the counter to stall and makes the dropped-byte path reachable. Each of these cases runs in a few hundred master clocks.

// File: rtl/dpkt_pkg.sv
package dpkt_pkg;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_FRAME1,
    ST_GAP,
    ST_FRAME2
  } tx_state_e;

  localparam int BYTE_W     = 8;
  localparam int FRAME_BITS = BYTE_W + 3;
  localparam logic [3:0] LAST_BIT = 4'(FRAME_BITS - 1);

  // Level on the line for position idx of a frame carrying byte b.
  function automatic logic frame_bit(input logic [BYTE_W-1:0] b, input logic [3:0] idx);
    logic [FRAME_BITS-1:0] packed_frame;
    packed_frame = {2'b11, b, 1'b0};
    if (idx > LAST_BIT) return 1'b1;
    return packed_frame[idx];
  endfunction

  // Counter increment that wraps at the end of the cycle.
  function automatic int unsigned next_count(input int unsigned cur, input int unsigned period);
    return (cur == period - 1) ? 0 : cur + 1;
  endfunction

endpackage

// File: rtl/dpkt_sclk_sync.sv
module dpkt_sclk_sync #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sclk_in,
  output logic sclk_fall
);
  // Synchroniser stages, plus one more stage used only to detect the falling edge.
  logic [SYNC_STAGES:0] sh;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh <= '1;
    else        sh <= {sh[SYNC_STAGES-1:0], sclk_in};
  end

  assign sclk_fall = sh[SYNC_STAGES] & ~sh[SYNC_STAGES-1];
endmodule

// File: rtl/dpkt_cycle_timer.sv
module dpkt_cycle_timer #(
  parameter int PERIOD   = 1024,
  parameter int HIGH_CYC = 4,
  parameter int WORD_W   = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              hold_req,
  input  logic [WORD_W-1:0] word_in,
  output logic              rdy_n,
  output logic              ready_gate,
  output logic              in_window,
  output logic [WORD_W-1:0] word_q
);
  localparam int CW = $clog2(PERIOD);
  localparam logic [CW-1:0] WIN_START = CW'(PERIOD - HIGH_CYC);
  localparam logic [CW-1:0] GATE_PT   = CW'(PERIOD - HIGH_CYC - 1);
  localparam logic [CW-1:0] LAST_PT   = CW'(PERIOD - 1);

  logic [CW-1:0] cnt;
  logic          wrap;
  logic          stall;

  assign wrap       = (cnt == LAST_PT);
  assign ready_gate = (cnt == GATE_PT);
  assign in_window  = (cnt >= WIN_START);
  assign stall      = ready_gate & hold_req;
  assign rdy_n      = in_window;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt    <= WIN_START;
      word_q <= '0;
    end else begin
      if (!stall) cnt <= CW'(dpkt_pkg::next_count(32'(cnt), PERIOD));
      if (wrap)   word_q <= word_in;
    end
  end
endmodule

// File: rtl/dpkt_frame_seq.sv
module dpkt_frame_seq
  import dpkt_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        sclk_fall,
  input  logic        cs_n,
  input  logic        in_window,
  input  logic        ready_gate,
  input  logic [15:0] word_q,
  output logic        sdo_o,
  output logic        sdo_en,
  output logic        busy
);
  tx_state_e  state;
  logic [3:0] bidx;
  logic       start1;
  logic       at_last;
  logic [7:0] cur_byte;

  assign start1   = (state == ST_IDLE) && sclk_fall && !cs_n && !in_window;
  assign at_last  = (bidx == LAST_BIT);
  assign busy     = (state == ST_FRAME1) || (state == ST_FRAME2) ||
                    ((state == ST_GAP) && !cs_n) || start1;
  assign sdo_en   = (state == ST_FRAME1) || (state == ST_FRAME2);
  assign cur_byte = (state == ST_FRAME1) ? word_q[15:8] : word_q[7:0];
  assign sdo_o    = sdo_en ? frame_bit(cur_byte, bidx) : 1'b1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= ST_IDLE;
      bidx  <= '0;
    end else begin
      unique case (state)
        ST_IDLE: if (start1) begin
          state <= ST_FRAME1;
          bidx  <= '0;
        end
        ST_FRAME1: if (sclk_fall) begin
          if (at_last) begin
            bidx  <= '0;
            state <= cs_n ? ST_GAP : ST_FRAME2;
          end else begin
            bidx <= bidx + 4'd1;
          end
        end
        ST_GAP: begin
          if (!cs_n) begin
            state <= ST_FRAME2;
            bidx  <= '0;
          end else if (ready_gate) begin
            state <= ST_IDLE;
          end
        end
        ST_FRAME2: if (sclk_fall) begin
          if (at_last) begin
            bidx  <= '0;
            state <= ST_IDLE;
          end else begin
            bidx <= bidx + 4'd1;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/dpkt_uart_tx.sv
module dpkt_uart_tx #(
  parameter int PERIOD      = 1024,
  parameter int HIGH_CYC    = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        sclk_in,
  input  logic        cs_n,
  input  logic [15:0] word_in,
  output logic        rdy_n,
  output logic        sdo_o,
  output logic        sdo_en
);
  logic        sclk_fall;
  logic        busy;
  logic        ready_gate;
  logic        in_window;
  logic [15:0] word_q;

  dpkt_sclk_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
    .clk      (clk),
    .rst_n    (rst_n),
    .sclk_in  (sclk_in),
    .sclk_fall(sclk_fall)
  );

  dpkt_cycle_timer #(.PERIOD(PERIOD), .HIGH_CYC(HIGH_CYC), .WORD_W(16)) u_timer (
    .clk       (clk),
    .rst_n     (rst_n),
    .hold_req  (busy),
    .word_in   (word_in),
    .rdy_n     (rdy_n),
    .ready_gate(ready_gate),
    .in_window (in_window),
    .word_q    (word_q)
  );

  dpkt_frame_seq u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .sclk_fall (sclk_fall),
    .cs_n      (cs_n),
    .in_window (in_window),
    .ready_gate(ready_gate),
    .word_q    (word_q),
    .sdo_o     (sdo_o),
    .sdo_en    (sdo_en),
    .busy      (busy)
  );
endmodule

// File: rtl/dpkt_uart_tx_chk.sv
module dpkt_uart_tx_chk #(
  parameter int HIGH_CYC = 4
) (
  input logic        clk,
  input logic        rst_n,
  input logic        rdy_n,
  input logic        sdo_o,
  input logic        sdo_en,
  input logic        sclk_fall,
  input logic [15:0] word_q
);
  AST_WORD_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    sdo_en |=> $stable(word_q)); // R10

  AST_QUIET_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
    rdy_n |-> !sdo_en); // R10

  AST_START_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sdo_en) |-> !sdo_o); // R3

  AST_BIT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (sdo_en && $past(sdo_en) && !$past(sclk_fall)) |-> $stable(sdo_o)); // R3

  AST_WINDOW_WIDTH: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(rdy_n) |-> $past(rdy_n, HIGH_CYC)); // R2

  AST_RELEASE_AFTER_STOP: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sdo_en) |-> $past(sdo_o)); // R6
endmodule

bind dpkt_uart_tx dpkt_uart_tx_chk #(.HIGH_CYC(HIGH_CYC)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .rdy_n    (rdy_n),
  .sdo_o    (sdo_o),
  .sdo_en   (sdo_en),
  .sclk_fall(sclk_fall),
  .word_q   (word_q)
);

// File: tb/dpkt_uart_tx_tb.sv
module dpkt_uart_tx_tb;
  localparam int CLK_PERIOD = 10;
  localparam int P_CYC      = 256;
  localparam int H_CYC      = 4;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        sclk_in;
  logic        cs_n;
  logic [15:0] word_in;
  logic        rdy_n;
  logic        sdo_o;
  logic        sdo_en;

  int tests  = 0;
  int fails  = 0;
  bit done   = 0;
  int rdy_hi_cnt = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dpkt_uart_tx #(.PERIOD(P_CYC), .HIGH_CYC(H_CYC)) u_dut (
    .clk(clk), .rst_n(rst_n), .sclk_in(sclk_in), .cs_n(cs_n),
    .word_in(word_in), .rdy_n(rdy_n), .sdo_o(sdo_o), .sdo_en(sdo_en)
  );

  always @(negedge clk) if (rdy_n === 1'b1) rdy_hi_cnt++;

  function automatic logic [10:0] exp_frame(input logic [7:0] b);
    logic [10:0] f;
    f[0] = 1'b0;
    for (int i = 0; i < 8; i++) f[i+1] = b[i];
    f[9]  = 1'b1;
    f[10] = 1'b1;
    return f;
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic shift(input int half, output logic b, output logic e);
    sclk_in = 1'b0;
    repeat (half) @(negedge clk);
    sclk_in = 1'b1;
    repeat (half) @(negedge clk);
    b = sdo_o;
    e = sdo_en;
  endtask

  task automatic wait_rdy_fall();
    while (rdy_n !== 1'b1) @(negedge clk);
    while (rdy_n !== 1'b0) @(negedge clk);
  endtask

  // One full two-frame transfer; hold keeps cs_n low throughout, otherwise short pulses.
  task automatic xfer(input int half, input bit hold, input logic [15:0] w, input string tag);
    logic [10:0] f1, f2;
    logic b, e;
    int en_ok;
    int hi0;
    en_ok = 1;
    hi0 = rdy_hi_cnt;
    cs_n = 1'b0;
    for (int i = 0; i < 11; i++) begin
      shift(half, b, e);
      f1[i] = b;
      if (!e) en_ok = 0;
      if (!hold && i == 1) cs_n = 1'b1;
    end
    check({tag, " R3 R4 high-byte frame"}, 32'(f1), 32'(exp_frame(w[15:8])));
    if (hold) begin
      for (int i = 0; i < 11; i++) begin
        shift(half, b, e);
        f2[i] = b;
        if (!e) en_ok = 0;
      end
      check({tag, " R9 ready stayed low over 22 bits"}, 32'(rdy_hi_cnt - hi0), 32'd0);
      cs_n = 1'b1;
    end else begin
      shift(half, b, e);
      check({tag, " R6 released after second stop"}, {31'd0, e}, 32'd0);
      check({tag, " R11 idle line high"}, {31'd0, b}, 32'd1);
      cs_n = 1'b0;
      repeat (2) @(negedge clk);
      cs_n = 1'b1;
      repeat (2) @(negedge clk);
      f2[0] = sdo_o;
      if (!sdo_en) en_ok = 0;
      for (int i = 1; i < 11; i++) begin
        shift(half, b, e);
        f2[i] = b;
        if (!e) en_ok = 0;
      end
    end
    check({tag, " R4 R7 low-byte frame"}, 32'(f2), 32'(exp_frame(w[7:0])));
    check({tag, " R11 enable held during frames"}, 32'(en_ok), 32'd1);
    shift(half, b, e);
    check({tag, " R11 enable off after transfer"}, {31'd0, e}, 32'd0);
  endtask

  initial begin
    logic b, e;
    int n;
    int hi0;
    logic [15:0] w1, w2, w3, w4;
    void'($urandom(32'h1d5e));
    sclk_in = 1'b1;
    cs_n    = 1'b1;
    word_in = 16'hA5C3;
    rst_n   = 1'b0;
    repeat (5) @(negedge clk);
    check("R1 rdy_n in reset", {31'd0, rdy_n}, 32'd1);
    check("R1 sdo_en in reset", {31'd0, sdo_en}, 32'd0);
    check("R1 R11 sdo_o in reset", {31'd0, sdo_o}, 32'd1);
    rst_n = 1'b1;
    n = 0;
    forever begin
      @(negedge clk);
      if (rdy_n) n++; else break;
    end
    check("R1 ready falls on edge HIGH_CYC", 32'(n), 32'(H_CYC - 1));

    // R2: low and high lengths of an idle cycle
    n = 0;
    while (rdy_n == 1'b0) begin n++; @(negedge clk); end
    check("R2 low length", 32'(n), 32'(P_CYC - H_CYC));
    n = 0;
    while (rdy_n == 1'b1) begin n++; @(negedge clk); end
    check("R2 high length", 32'(n), 32'(H_CYC));

    // Fast transfer with short pulses on the reset-loaded word (R3 R4 R6 R7)
    xfer(4, 1'b0, 16'hA5C3, "pulse-fast");

    // R5: no start without shift edge, nor with cs_n high
    cs_n = 1'b0;
    repeat (40) @(negedge clk);
    check("R5 cs low alone", {31'd0, sdo_en}, 32'd0);
    cs_n = 1'b1;
    for (int i = 0; i < 3; i++) begin
      shift(4, b, e);
      check("R5 shift edges with cs high", {31'd0, e}, 32'd0);
    end

    // R8: slow frame one overruns the gate, low byte dropped
    w1 = 16'h3C96;
    w2 = 16'hE107;
    word_in = w1;
    wait_rdy_fall();
    word_in = w2;
    cs_n = 1'b0;
    begin
      logic [10:0] f1;
      for (int i = 0; i < 11; i++) begin
        shift(16, b, e);
        f1[i] = b;
        if (i == 1) cs_n = 1'b1;
      end
      check("R8 R3 slow high-byte frame", 32'(f1), 32'(exp_frame(w1[15:8])));
    end
    hi0 = rdy_hi_cnt;
    shift(16, b, e);
    check("R8 released", {31'd0, e}, 32'd0);
    check("R8 ready rose after drop", 32'(rdy_hi_cnt - hi0), 32'(H_CYC));
    cs_n = 1'b0;
    repeat (3) @(negedge clk);
    cs_n = 1'b1;
    repeat (2) @(negedge clk);
    check("R8 late pulse ignored", {31'd0, sdo_en}, 32'd0);
    wait_rdy_fall();
    xfer(4, 1'b1, w2, "R8 replaced-word");

    // R9 R10: slow held transfer, word changes meanwhile
    w3 = 16'h5AF0;
    w4 = 16'h0FF1;
    word_in = w3;
    wait_rdy_fall();
    word_in = w4;
    xfer(16, 1'b1, w3, "R9 R10 held-slow");
    wait_rdy_fall();
    xfer(4, 1'b1, w4, "R10 next-word");

    // Random mix
    for (int k = 0; k < 4; k++) begin
      logic [15:0] wr;
      bit hold;
      int half;
      wr = 16'($urandom);
      word_in = wr;
      wait_rdy_fall();
      word_in = 16'($urandom);
      hold = bit'($urandom % 2);
      half = 4 + int'($urandom % 2);
      xfer(half, hold, wr, "random");
    end

    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      tests++;
      fails++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule